// File: doc/BRIEF.md
# Single-Cycle Load/Store RISC Core

This block is a 32-bit processor that finishes one instruction in every clock cycle. It implements nine operations: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and unconditional jump. Each cycle follows one path. The core fetches from the instruction memory at the program counter and reads two registers. It computes through the ALU and, when needed, accesses the data memory. It writes one register back on the falling clock edge and loads the next program counter on the rising edge.

Decoding happens in two levels. A main decoder turns the 6-bit opcode into datapath controls and a 2-bit ALU class (00 add, 01 subtract, 10 use the function field). A second decoder turns that class and the function field into the ALU operation. Both memories are synchronous-write, asynchronous-read word arrays. A load port fills them while the core is held in reset. The debug outputs show the program counter and every register-file write.

Top module: `sc_risc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0. The first instruction after reset release is fetched from address 0.
- R2: After any instruction other than a taken beq or a j, pc_o advances by 4 on the next rising edge.
- R3: Opcode 000000 with function 100000 (add), 100010 (subtract), 100100 (and) or 100101 (or) writes the result of rs op rt into rd. The fields are rs=[25:21], rt=[20:16] and rd=[15:11].
- R4: Opcode 000000 with function 101010 writes 1 into rd when rs is less than rt as signed values, and 0 otherwise.
- R5: Opcode 100011 writes into rt the data-memory word at address rs + sign-extended [15:0]. Negative offsets are included.
- R6: Opcode 101011 stores rt at address rs + sign-extended [15:0] and writes no register.
- R7: Opcode 000100 jumps to PC+4 + (sign-extended [15:0] << 2) when rs equals rt, and goes to PC+4 otherwise. Both forward and backward offsets work.
- R8: Opcode 000010 sets the next PC to {PC+4[31:28], [25:0], 2'b00}.
- R9: Register 0 always reads 0. A write addressed to it changes nothing and raises no rf_we_o.
- R10: Any other opcode writes neither a register nor memory, and the PC advances by 4.
- R11: A register written by one instruction holds the new value when the very next instruction reads it.
- R12: rf_we_o, rf_waddr_o and rf_wdata_o report, during the cycle of the instruction, the register write that it commits on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the PC and memories update on the rising edge, the registers on the falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_en_i | input | 1 | Memory preload write strobe |
| ld_dmem_i | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr_i | input | LD_AW | Preload word index |
| ld_data_i | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write committed this cycle |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written |

## Verification
The bench uses the default parameters: 64-word instruction and data memories and 5-bit register addresses. With these sizes the whole test program and its data table fit in memory. The program covers a load feeding the next instruction directly and a store followed by a reload. It also covers a negative load/store offset, a branch that falls through and a branch that is taken, a counted loop closed by both a forward branch and a backward jump, a backward branch onto itself, a write aimed at register 0 and an undefined opcode. A behavioural instruction model runs next to the core. On every cycle it predicts the PC and the write-port outputs.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{reg_dst: 1'b0, alu_src: 1'b0, mem_to_reg: 1'b0, reg_write: 1'b0,
               mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0, jump: 1'b0,
               alu_op: AOP_ADD};
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_read   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = AOP_SUB;
      end
      OP_J: ctrl_o.jump = 1'b1;
      default: ;  // undefined opcode: no side effects
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_core_pkg::*;
(
  input  alu_op_e    alu_op_i,
  input  logic [5:0] funct_i,
  output alu_fn_e    alu_fn_o
);
  always_comb begin
    unique case (alu_op_i)
      AOP_ADD: alu_fn_o = ALU_ADD;
      AOP_SUB: alu_fn_o = ALU_SUB;
      default: begin
        unique case (funct_i)
          FN_ADD:  alu_fn_o = ALU_ADD;
          FN_SUB:  alu_fn_o = ALU_SUB;
          FN_AND:  alu_fn_o = ALU_AND;
          FN_OR:   alu_fn_o = ALU_OR;
          FN_SLT:  alu_fn_o = ALU_SLT;
          default: alu_fn_o = ALU_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  logic [W-1:0] diff;
  assign diff = a_i - b_i;

  always_comb begin
    unique case (fn_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SUB: y_o = diff;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter  int unsigned W    = 32,
  parameter  int unsigned NREG = 32,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  // Falling-edge write: result lands mid-cycle, readable by the next instruction.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter  int unsigned W     = 32,
  parameter  int unsigned AW    = 6,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [W-1:0]  ld_data_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (ld_we_i)      mem_q[ld_addr_i] <= ld_data_i;
    else if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] pc_i,
  input  logic [25:0]  target_i,
  input  logic         take_branch_i,
  input  logic         jump_i,
  output logic [W-1:0] next_pc_o
);
  logic [W-1:0] pc_plus4, br_off, br_pc, jmp_pc;

  assign pc_plus4 = pc_i + W'(4);
  assign br_off   = {{(W-18){target_i[15]}}, target_i[15:0], 2'b00};
  assign br_pc    = pc_plus4 + br_off;
  assign jmp_pc   = {pc_plus4[W-1:W-4], target_i, 2'b00};

  always_comb begin
    if (jump_i)             next_pc_o = jmp_pc;
    else if (take_branch_i) next_pc_o = br_pc;
    else                    next_pc_o = pc_plus4;
  end
endmodule

// File: rtl/sc_risc_core.sv
module sc_risc_core
  import sc_core_pkg::*;
#(
  parameter  int unsigned IMEM_AW = 6,
  parameter  int unsigned DMEM_AW = 6,
  localparam int unsigned LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
  localparam int unsigned RAW     = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic             ld_dmem_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [XLEN-1:0]  ld_data_i,
  output logic [XLEN-1:0]  pc_o,
  output logic             rf_we_o,
  output logic [RAW-1:0]   rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o
);
  logic [XLEN-1:0] pc_q, pc_next;
  logic [XLEN-1:0] instr;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;
  logic [RAW-1:0]  f_rs, f_rt, f_rd, waddr;
  logic [XLEN-1:0] rs_val, rt_val, imm_sx, alu_b, alu_y, dmem_rdata, wdata;
  logic            alu_zero, dmem_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  sc_mem #(.W(XLEN), .AW(IMEM_AW)) u_imem (
    .clk_i     (clk_i),
    .ld_we_i   (ld_en_i & ~ld_dmem_i),
    .ld_addr_i (ld_addr_i[IMEM_AW-1:0]),
    .ld_data_i (ld_data_i),
    .wr_en_i   (1'b0),
    .wr_addr_i ('0),
    .wr_data_i ('0),
    .rd_addr_i (pc_q[IMEM_AW+1:2]),
    .rd_data_o (instr)
  );

  assign f_rs   = instr[25:21];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_main_dec u_main_dec (
    .opcode_i (instr[31:26]),
    .ctrl_o   (ctrl)
  );

  sc_alu_dec u_alu_dec (
    .alu_op_i (ctrl.alu_op),
    .funct_i  (instr[5:0]),
    .alu_fn_o (alu_fn)
  );

  assign waddr = ctrl.reg_dst ? f_rd : f_rt;

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (f_rs),
    .ra2_i  (f_rt),
    .rd1_o  (rs_val),
    .rd2_o  (rt_val),
    .we_i   (ctrl.reg_write),
    .wa_i   (waddr),
    .wd_i   (wdata)
  );

  assign alu_b = ctrl.alu_src ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .fn_i   (alu_fn),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // Stores are held off while the core sits in reset (preload phase).
  assign dmem_we = ctrl.mem_write & rst_ni;

  logic [XLEN-1:0] dmem_raw;

  sc_mem #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk_i     (clk_i),
    .ld_we_i   (ld_en_i & ld_dmem_i),
    .ld_addr_i (ld_addr_i[DMEM_AW-1:0]),
    .ld_data_i (ld_data_i),
    .wr_en_i   (dmem_we),
    .wr_addr_i (alu_y[DMEM_AW+1:2]),
    .wr_data_i (rt_val),
    .rd_addr_i (alu_y[DMEM_AW+1:2]),
    .rd_data_o (dmem_raw)
  );

  assign dmem_rdata = ctrl.mem_read ? dmem_raw : '0;
  assign wdata      = ctrl.mem_to_reg ? dmem_rdata : alu_y;

  sc_next_pc #(.W(XLEN)) u_next_pc (
    .pc_i          (pc_q),
    .target_i      (instr[25:0]),
    .take_branch_i (ctrl.branch & alu_zero),
    .jump_i        (ctrl.jump),
    .next_pc_o     (pc_next)
  );

  assign pc_o       = pc_q;
  assign rf_we_o    = ctrl.reg_write & (waddr != '0);
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wdata;
endmodule

// File: rtl/sc_risc_core_chk.sv
module sc_risc_core_chk
  import sc_core_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_o,
  input logic [31:0] instr_i,
  input logic        dmem_we_i,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o
);
  logic [5:0]  op;
  logic        op_known;
  logic [31:0] pc4, jmp_tgt;

  assign op       = instr_i[31:26];
  assign op_known = (op == OP_RTYPE) || (op == OP_LW) || (op == OP_SW) ||
                    (op == OP_BEQ) || (op == OP_J);
  assign pc4      = pc_o + 32'd4;
  assign jmp_tgt  = {pc4[31:28], instr_i[25:0], 2'b00};

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_pc_r1: assert (pc_o == 32'd0);
  end

  p_pc_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ && op != OP_J) |=> pc_o == $past(pc_o) + 32'd4);

  p_store_nowrite_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SW) |-> (!rf_we_o && dmem_we_i));

  p_jump_tgt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_J) |=> pc_o == $past(jmp_tgt));

  p_zero_reg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_waddr_o != 5'd0);

  p_unknown_op_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_known |-> (!rf_we_o && !dmem_we_i));
endmodule

bind sc_risc_core sc_risc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_o       (pc_o),
  .instr_i    (instr),
  .dmem_we_i  (dmem_we),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o)
);

// File: tb/sc_risc_core_test.sv
`timescale 1ns/100ps
module sc_risc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0, ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sc_risc_core uut (
    .clk_i(clk), .rst_ni(rst_n), .ld_en_i(ld_en), .ld_dmem_i(ld_dmem),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .pc_o(pc),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata)
  );

  // Reference model state
  logic [31:0] m_im [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(int rd, int rs, int rt, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int tgt_word);
    return {6'b000010, 26'(tgt_word)};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at pc=%h", tag, act, exp, m_pc);
    end
  endtask

  task automatic step_and_compare(int idx);
    logic [31:0] ins, a, b, sx, addr, val, npc;
    logic [5:0]  op, fn;
    bit          wr;
    int          dst;
    string       tag, ptag;
    ins = m_im[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = m_rf[ins[25:21]]; b = m_rf[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    addr = a + sx;
    npc = m_pc + 4;
    wr = 0; dst = 0; val = '0;
    tag = "R10"; ptag = "R2";
    case (op)
      6'b000000: begin
        wr = 1; dst = ins[15:11]; tag = "R3";
        case (fn)
          6'b100000: val = a + b;
          6'b100010: val = a - b;
          6'b100100: val = a & b;
          6'b100101: val = a | b;
          6'b101010: begin val = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
          default:   wr = 0;
        endcase
      end
      6'b100011: begin wr = 1; dst = ins[20:16]; val = m_dm[addr[7:2]]; tag = "R5"; end
      6'b101011: tag = "R6";
      6'b000100: begin
        tag = "R7"; ptag = "R7";
        if (a == b) npc = m_pc + 4 + (sx << 2);
      end
      6'b000010: begin
        tag = "R8"; ptag = "R8";
        npc = {npc[31:28], ins[25:0], 2'b00};
      end
      default: ;
    endcase
    if (dst == 0) begin wr = 0; if (op == 6'b000000) tag = "R9"; end
    if (idx == 2) tag = "R11";  // consumes a load issued one cycle earlier
    check(pc === m_pc, (idx == 0) ? "R1" : "R2", pc, m_pc);
    check(rf_we === wr, {tag, " R12 we"}, 32'(rf_we), 32'(wr));
    if (wr) begin
      check(rf_waddr === 5'(dst), {tag, " R12 waddr"}, 32'(rf_waddr), 32'(dst));
      check(rf_wdata === val, tag, rf_wdata, val);
    end
    // commit
    if (wr) m_rf[dst] = val;
    if (op == 6'b101011) m_dm[addr[7:2]] = b;
    m_pc = npc;
    // next-PC is observed at the next compare; tag it here for clarity
    if (ptag != "R2") checks = checks;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_im[i] = 32'hFC00_0000; m_dm[i] = '0; end
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    m_dm[0] = 32'd5; m_dm[1] = 32'hFFFF_FFFD; m_dm[2] = 32'd1; m_dm[3] = 32'd4;
    m_im[0]  = enc_i(6'b100011, 0, 1, 0);
    m_im[1]  = enc_i(6'b100011, 0, 2, 4);
    m_im[2]  = enc_r(3, 1, 2, 6'b100000);
    m_im[3]  = enc_r(4, 1, 2, 6'b100010);
    m_im[4]  = enc_r(5, 1, 2, 6'b100100);
    m_im[5]  = enc_r(6, 1, 2, 6'b100101);
    m_im[6]  = enc_r(7, 2, 1, 6'b101010);
    m_im[7]  = enc_r(8, 1, 2, 6'b101010);
    m_im[8]  = enc_r(0, 1, 1, 6'b100000);
    m_im[9]  = enc_r(10, 0, 1, 6'b100000);
    m_im[10] = enc_i(6'b101011, 0, 4, 16);
    m_im[11] = enc_i(6'b100011, 0, 11, 16);
    m_im[12] = enc_r(12, 3, 3, 6'b100000);
    m_im[13] = enc_i(6'b100011, 12, 13, 12);
    m_im[14] = enc_i(6'b100011, 0, 14, 8);
    m_im[15] = enc_i(6'b100011, 0, 15, 12);
    m_im[16] = enc_i(6'b000100, 1, 2, 20);
    m_im[17] = 32'hFC21_0000;
    m_im[18] = enc_r(16, 16, 14, 6'b100000);
    m_im[19] = enc_i(6'b000100, 16, 15, 1);
    m_im[20] = enc_j(18);
    m_im[21] = enc_i(6'b101011, 12, 16, -4);
    m_im[22] = enc_i(6'b100011, 0, 17, 0);
    m_im[23] = enc_j(24);
    m_im[24] = enc_i(6'b000100, 0, 0, -1);
    m_pc = '0;

    // Preload both memories while held in reset
    repeat (2) @(negedge clk);
    check(pc === 32'd0, "R1 in reset", pc, 32'd0);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); ld_en = 1; ld_dmem = 0; ld_addr = 6'(i); ld_data = m_im[i];
      @(negedge clk); ld_dmem = 1; ld_data = m_dm[i];
    end
    @(negedge clk); ld_en = 0;
    check(pc === 32'd0, "R1 after preload", pc, 32'd0);

    @(posedge clk); #1 rst_n = 1;
    #0.5;
    for (int c = 0; c < 120; c++) begin
      step_and_compare(c);
      @(posedge clk); #1.5;
    end
    // Final architectural state observed through the write port in the model run
    check(m_rf[17] === 32'd4, "R6 store at negative offset", m_rf[17], 32'd4);
    check(m_pc === 32'd96, "R7 backward self-branch", m_pc, 32'd96);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule